// File: doc/BRIEF.md
# Width-Converting Packing DMA FIFO

This block is the data buffer that sits between a narrow peripheral data port and a 32-bit local memory bus inside a DMA channel. It holds eight words of four bytes. In the peripheral-to-memory direction it gathers 8-bit or 16-bit peripheral beats into full 32-bit words, so the local bus always moves whole words where it can. In the memory-to-peripheral direction it cuts each 32-bit word into beats of the port width, lowest byte lane first.

The local-side address of a transfer need not be word aligned. A start pulse loads the direction, the port width and the low two bits of the local start address. When packing, the first peripheral byte goes to the lane named by that offset, and every word carries byte enables that mark its valid lanes. When unpacking, the lanes below the offset in the first word are skipped. A flush request at the end of a packing transfer pushes out the last, partly filled word with enables only on its filled lanes. The block has no address or byte counters and no bus timing of its own. Full, empty and level outputs report the buffer occupancy.

Top module: `dma_pack_fifo`

## Requirements
- R1: After reset the buffer is empty: `empty`=1, `full`=0, `level`=0, `lo_valid`=0, `po_valid`=0, and the direction is packing with 8-bit beats and offset 0.
- R2: `cfg_width` encodes the port width as 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. The beat's bytes are taken from `pi_data` lowest byte first. When packing, they fill byte lanes little-endian, and the first byte after a start goes to lane `cfg_offset`. A beat may run past lane 3, and its remaining bytes then start the next word at lane 0.
- R3: A word enters the buffer in the same cycle as the beat that fills lane 3. Its `lo_be` bit n is 1 for each lane n that was written, so the first word after an offset of k has enables only on lanes k to 3.
- R4: A `flush` pulse pushes the partly filled word, with enables only on its filled lanes. If no lane is filled it pushes nothing. If the buffer is full and no word leaves that cycle, the flush stays pending until space appears. `pi_ready` is 0 while a flush is requested or pending.
- R5: The buffer holds 8 words. `level` gives the word count, `full` is 1 exactly at 8 words, and `empty` is 1 exactly at 0.
- R6: When full, `pi_ready` is 0 unless `lo_pop` takes a word in the same cycle. A push together with a pop at full keeps `level` at 8 and loses no word.
- R7: `lo_valid` is 1 only in packing direction with the buffer not empty, and `lo_data`/`lo_be` show the oldest word. `lo_pop` while empty has no effect.
- R8: When unpacking, `po_data` carries beats of the port width in the low bytes (upper bytes 0). Bytes come out in lane order across successive words, starting at lane `cfg_offset` of the first word. A beat may combine the end of one word with the start of the next. `po_valid` is 1 when at least one beat's bytes are held.
- R9: When unpacking, a word is accepted on `li_push` while `li_ready`=1. `li_ready` is 0 when the buffer is full, unless the unpacker takes a word in the same cycle.
- R10: A `start` pulse empties the buffer, clears any partial word and any pending flush, and loads `cfg_dir`, `cfg_width` and `cfg_offset`. In that cycle `pi_ready`, `li_ready` and `po_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer: clear contents, load configuration |
| cfg_dir | input | 1 | 0 = peripheral to memory (pack), 1 = memory to peripheral (unpack) |
| cfg_width | input | 2 | Peripheral port width: 0 = 8, 1 = 16, 2/3 = 32 bits |
| cfg_offset | input | 2 | Low two bits of the local start address |
| pi_valid | input | 1 | Peripheral beat offered (pack) |
| pi_data | input | 32 | Peripheral beat, lowest byte first |
| pi_ready | output | 1 | Beat accepted this cycle when pi_valid is 1 |
| flush | input | 1 | Push out the partly filled word (pack) |
| lo_valid | output | 1 | A packed word is available to the local bus |
| lo_data | output | 32 | Oldest packed word |
| lo_be | output | 4 | Byte enables of the oldest packed word |
| lo_pop | input | 1 | Local bus takes the oldest word |
| li_push | input | 1 | Local bus offers a word (unpack) |
| li_data | input | 32 | Word from local memory |
| li_ready | output | 1 | Word accepted this cycle when li_push is 1 |
| po_valid | output | 1 | A peripheral beat is available (unpack) |
| po_data | output | 32 | Peripheral beat in the low bytes |
| po_pop | input | 1 | Peripheral takes the beat |
| full | output | 1 | Buffer holds 8 words |
| empty | output | 1 | Buffer holds no word |
| level | output | 4 | Number of words held |

## Verification
The bench goes after beats that cross a word boundary: 32-bit beats at offset 1 or 3, and 16-bit beats at an odd offset. A design that wrapped lanes wrongly would drop or duplicate the spill-over byte, or would put it in the wrong word. It fills the buffer with a partial word still staged and then flushes. A design without a pending flush would lose that tail, and one that ignored the enables would report garbage lanes as valid. It also pushes and pops together at full and pops while empty. A level counter that mishandled these would drift or wrap. In the unpack direction it skips the leading lanes of the first word only. A design that applied the offset to every word would lose bytes on each word.

// File: rtl/dpf_pkg.sv
package dpf_pkg;

    localparam int LANES    = 4;
    localparam int BYTE_W   = 8;
    localparam int WORD_W   = LANES * BYTE_W;

    typedef enum logic [1:0] {
        PW_8   = 2'd0,
        PW_16  = 2'd1,
        PW_32  = 2'd2,
        PW_32X = 2'd3
    } pw_e;

    typedef struct packed {
        logic [LANES-1:0]  be;
        logic [WORD_W-1:0] data;
    } word_t;

    // bytes carried by one peripheral beat
    function automatic logic [2:0] beat_bytes(pw_e w);
        case (w)
            PW_8:    beat_bytes = 3'd1;
            PW_16:   beat_bytes = 3'd2;
            default: beat_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dpf_store.sv
module dpf_store
    import dpf_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  word_t         wdata,
    output word_t         rdata,
    output logic          full,
    output logic          empty,
    output logic [LW-1:0] level
);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [LW-1:0] cnt;
    } ptr_t;

    ptr_t  st_d, st_q;
    word_t mem [DEPTH];
    logic  do_push, do_pop;

    function automatic logic [AW-1:0] adv(logic [AW-1:0] p);
        adv = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && (st_q.cnt != '0);
        do_push = push && ((st_q.cnt != LW'(DEPTH)) || do_pop);
        if (clr) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wr = adv(st_q.wr);
            if (do_pop)  st_d.rd = adv(st_q.rd);
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[st_q.wr] <= wdata;
    end

    assign rdata = mem[st_q.rd];
    assign full  = (st_q.cnt == LW'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign level = st_q.cnt;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !clr) |-> !full) else $error("overflow push"); // R6

    AST_FILL_TO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !clr && level == LW'(DEPTH - 1)) |=> full) else $error("no full"); // R5

    AST_POP_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !clr) |=> empty) else $error("pop on empty"); // R7

    AST_LEVEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !empty && !clr) |=> $stable(level)) else $error("level drift"); // R6

endmodule

// File: rtl/dpf_packer.sv
module dpf_packer
    import dpf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  pw_e               width,
    input  logic [1:0]        clr_offset,
    input  logic              beat_valid,
    input  logic [WORD_W-1:0] beat_data,
    input  logic              flush,
    input  logic              space,
    output logic              beat_ready,
    output logic              push,
    output word_t             push_word
);

    typedef struct packed {
        word_t      stage;
        logic [1:0] pos;
        logic       fpend;
    } pk_t;

    pk_t        pk_d, pk_q;
    logic [2:0] nbytes;
    logic [2:0] lane;
    logic       req;
    logic       take;
    logic       wrap;
    word_t      cur, nxt;

    always_comb begin
        pk_d       = pk_q;
        nbytes     = beat_bytes(width);
        req        = flush | pk_q.fpend;
        beat_ready = en & ~req & space;
        take       = beat_valid & beat_ready;
        wrap       = ({1'b0, pk_q.pos} + nbytes) >= 3'd4;
        push       = 1'b0;
        push_word  = pk_q.stage;
        cur        = pk_q.stage;
        nxt        = '0;
        lane       = '0;

        // place each byte of the beat, spilling past lane 3 into the next word
        for (int i = 0; i < LANES; i++) begin
            if (3'(i) < nbytes) begin
                lane = {1'b0, pk_q.pos} + 3'(i);
                if (!lane[2]) begin
                    cur.data[{lane[1:0], 3'b000} +: BYTE_W] = beat_data[i*BYTE_W +: BYTE_W];
                    cur.be[lane[1:0]] = 1'b1;
                end else begin
                    nxt.data[{lane[1:0], 3'b000} +: BYTE_W] = beat_data[i*BYTE_W +: BYTE_W];
                    nxt.be[lane[1:0]] = 1'b1;
                end
            end
        end

        if (clr) begin
            pk_d.stage = '0;
            pk_d.pos   = clr_offset;
            pk_d.fpend = 1'b0;
        end else if (take) begin
            push       = wrap;
            push_word  = cur;
            pk_d.stage = wrap ? nxt : cur;
            pk_d.pos   = pk_q.pos + nbytes[1:0];
        end else if (en && req) begin
            if (pk_q.stage.be != '0) begin
                if (space) begin
                    push       = 1'b1;
                    push_word  = pk_q.stage;
                    pk_d.stage = '0;
                    pk_d.pos   = '0;
                    pk_d.fpend = 1'b0;
                end else begin
                    pk_d.fpend = 1'b1;
                end
            end else begin
                pk_d.fpend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    AST_PUSH_HAS_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (push_word.be != '0)) else $error("empty word pushed"); // R4

    AST_BEAT_WORD_TOP_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (push && take) |-> push_word.be[LANES-1]) else $error("beat word short"); // R3

    AST_PEND_BLOCKS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_q.fpend && !clr) |-> !take) else $error("beat during flush"); // R4

endmodule

// File: rtl/dpf_unpacker.sv
module dpf_unpacker
    import dpf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  pw_e               width,
    input  logic [1:0]        clr_offset,
    input  logic              avail,
    input  logic [WORD_W-1:0] head_data,
    output logic              take,
    output logic              beat_valid,
    output logic [WORD_W-1:0] beat_data,
    input  logic              beat_pop
);

    localparam int BUF_W = 2 * WORD_W;

    typedef struct packed {
        logic [BUF_W-1:0] held;
        logic [3:0]       cnt;
        logic [1:0]       skip;
        logic             first;
    } up_t;

    up_t              up_d, up_q;
    logic [2:0]       nbytes;
    logic             fire;
    logic [1:0]       k;
    logic [3:0]       c2;
    logic [BUF_W-1:0] acc;
    logic [BUF_W-1:0] ins;

    always_comb begin
        up_d       = up_q;
        nbytes     = beat_bytes(width);
        beat_valid = en && (up_q.cnt >= {1'b0, nbytes});
        fire       = beat_pop && beat_valid;
        take       = en && avail && (up_q.cnt <= 4'd4);
        k          = up_q.first ? up_q.skip : 2'd0;
        ins        = {{WORD_W{1'b0}}, head_data} >> {k, 3'b000};
        acc        = up_q.held;
        c2         = up_q.cnt;

        if (fire) begin
            acc = acc >> {nbytes, 3'b000};
            c2  = up_q.cnt - {1'b0, nbytes};
        end
        if (take) begin
            acc = acc | (ins << {c2, 3'b000});
            c2  = c2 + 4'd4 - {2'b00, k};
        end

        case (nbytes)
            3'd1:    beat_data = {{(WORD_W-8){1'b0}},  up_q.held[7:0]};
            3'd2:    beat_data = {{(WORD_W-16){1'b0}}, up_q.held[15:0]};
            default: beat_data = up_q.held[WORD_W-1:0];
        endcase

        if (clr) begin
            up_d.held  = '0;
            up_d.cnt   = '0;
            up_d.skip  = clr_offset;
            up_d.first = 1'b1;
        end else begin
            up_d.held = acc;
            up_d.cnt  = c2;
            if (take) up_d.first = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) up_q <= '{held: '0, cnt: '0, skip: '0, first: 1'b1};
        else        up_q <= up_d;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        up_q.cnt <= 4'd8) else $error("byte holder overrun"); // R8

    AST_TAKE_CLEARS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !clr) |=> !up_q.first) else $error("offset reapplied"); // R8

endmodule

// File: rtl/dma_pack_fifo.sv
module dma_pack_fifo
    import dpf_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          cfg_dir,
    input  logic [1:0]    cfg_width,
    input  logic [1:0]    cfg_offset,
    input  logic          pi_valid,
    input  logic [31:0]   pi_data,
    output logic          pi_ready,
    input  logic          flush,
    output logic          lo_valid,
    output logic [31:0]   lo_data,
    output logic [3:0]    lo_be,
    input  logic          lo_pop,
    input  logic          li_push,
    input  logic [31:0]   li_data,
    output logic          li_ready,
    output logic          po_valid,
    output logic [31:0]   po_data,
    input  logic          po_pop,
    output logic          full,
    output logic          empty,
    output logic [LW-1:0] level
);

    typedef struct packed {
        logic dir;
        pw_e  width;
    } cfg_t;

    cfg_t  cfg_d, cfg_q;
    logic  en_pk, en_up;
    logic  lo_take, space;
    logic  pk_push;
    word_t pk_word;
    logic  up_take;
    logic  li_acc;
    logic  f_push, f_pop;
    word_t f_wdata, f_rdata;

    always_comb begin
        cfg_d = cfg_q;
        if (start) begin
            cfg_d.dir   = cfg_dir;
            cfg_d.width = pw_e'(cfg_width);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '{dir: 1'b0, width: PW_8};
        else        cfg_q <= cfg_d;
    end

    assign en_pk   = !cfg_q.dir && !start;
    assign en_up   =  cfg_q.dir && !start;
    assign lo_take = en_pk && lo_pop && !empty;
    assign space   = !full || lo_take;
    assign li_ready = en_up && (!full || up_take);
    assign li_acc  = li_push && li_ready;

    assign f_push  = cfg_q.dir ? li_acc : pk_push;
    assign f_pop   = cfg_q.dir ? up_take : lo_take;
    assign f_wdata = cfg_q.dir ? '{be: 4'hF, data: li_data} : pk_word;

    dpf_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .push  (f_push),
        .pop   (f_pop),
        .wdata (f_wdata),
        .rdata (f_rdata),
        .full  (full),
        .empty (empty),
        .level (level)
    );

    dpf_packer u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (start),
        .en         (en_pk),
        .width      (cfg_q.width),
        .clr_offset (cfg_offset),
        .beat_valid (pi_valid),
        .beat_data  (pi_data),
        .flush      (flush),
        .space      (space),
        .beat_ready (pi_ready),
        .push       (pk_push),
        .push_word  (pk_word)
    );

    dpf_unpacker u_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (start),
        .en         (en_up),
        .width      (cfg_q.width),
        .clr_offset (cfg_offset),
        .avail      (!empty),
        .head_data  (f_rdata.data),
        .take       (up_take),
        .beat_valid (po_valid),
        .beat_data  (po_data),
        .beat_pop   (po_pop)
    );

    assign lo_valid = !cfg_q.dir && !empty;
    assign lo_data  = f_rdata.data;
    assign lo_be    = f_rdata.be;

    AST_PI_BLOCK_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !lo_pop) |-> !pi_ready) else $error("beat taken while full"); // R6

    AST_LI_BLOCK_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !up_take) |-> !li_ready) else $error("word taken while full"); // R9

    AST_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> empty) else $error("start left data"); // R10

endmodule

// File: tb/sim_dma_pack_fifo.sv
`timescale 1ns/1ps
module sim_dma_pack_fifo;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, cfg_dir = 1'b0;
    logic [1:0]  cfg_width = 2'd0, cfg_offset = 2'd0;
    logic        pi_valid = 1'b0, flush = 1'b0, lo_pop = 1'b0;
    logic        li_push = 1'b0, po_pop = 1'b0;
    logic [31:0] pi_data = '0, li_data = '0;
    logic        pi_ready, lo_valid, li_ready, po_valid, full, empty;
    logic [31:0] lo_data, po_data;
    logic [3:0]  lo_be, level;

    always #2.5 clk = ~clk;

    dma_pack_fifo u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_dir(cfg_dir),
        .cfg_width(cfg_width), .cfg_offset(cfg_offset),
        .pi_valid(pi_valid), .pi_data(pi_data), .pi_ready(pi_ready),
        .flush(flush), .lo_valid(lo_valid), .lo_data(lo_data), .lo_be(lo_be),
        .lo_pop(lo_pop), .li_push(li_push), .li_data(li_data),
        .li_ready(li_ready), .po_valid(po_valid), .po_data(po_data),
        .po_pop(po_pop), .full(full), .empty(empty), .level(level)
    );

    int total = 0, bad = 0;
    bit finished = 0;

    // behavioural reference state
    bit          m_dir = 0;
    int          m_w = 1, m_off = 0, m_pos = 0;
    bit          m_fpend = 0, m_first = 1;
    logic [7:0]  stg [4];
    bit          sbe [4];
    logic [35:0] fq [$];
    logic [7:0]  bq [$];
    bit          acc_pi, acc_li;
    int          seq = 0;

    task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [35:0] stage_word();
        logic [35:0] r = '0;
        for (int l = 0; l < 4; l++) begin
            r[l*8 +: 8] = stg[l];
            r[32 + l]   = sbe[l];
        end
        return r;
    endfunction

    function automatic bit stage_any();
        return sbe[0] | sbe[1] | sbe[2] | sbe[3];
    endfunction

    task automatic clear_stage();
        for (int l = 0; l < 4; l++) begin stg[l] = 8'h00; sbe[l] = 0; end
    endtask

    // compare at the current (post-negedge) point, advance the model, move to next negedge
    task automatic cycle();
        int  cnt;
        bit  e_full, e_empty, space, req, e_pir, e_lov, uload, e_lir, e_pov;
        logic [31:0] e_po;
        logic [35:0] w;
        int k;
        #1;
        cnt     = fq.size();
        e_full  = (cnt == 8);
        e_empty = (cnt == 0);
        space   = !e_full || (lo_pop && cnt > 0 && !start && !m_dir);
        req     = flush || m_fpend;
        e_pir   = !start && !m_dir && !req && space;
        e_lov   = !m_dir && cnt > 0;
        uload   = !start && m_dir && cnt > 0 && bq.size() <= 4;
        e_lir   = !start && m_dir && (!e_full || uload);
        e_pov   = !start && m_dir && bq.size() >= m_w;
        e_po    = '0;
        if (e_pov) for (int i = 0; i < m_w; i++) e_po[i*8 +: 8] = bq[i];

        check(full === e_full,   "R5 full",  {35'b0, full},  {35'b0, e_full});
        check(empty === e_empty, "R5 empty", {35'b0, empty}, {35'b0, e_empty});
        check(level === 4'(cnt), "R5 level", {32'b0, level}, 36'(cnt));
        check(pi_ready === e_pir, "R6/R4 pi_ready", {35'b0, pi_ready}, {35'b0, e_pir});
        check(lo_valid === e_lov, "R7 lo_valid", {35'b0, lo_valid}, {35'b0, e_lov});
        if (e_lov)
            check({lo_be, lo_data} === fq[0], "R2/R3/R4 lo word", {lo_be, lo_data}, fq[0]);
        check(li_ready === e_lir, "R9 li_ready", {35'b0, li_ready}, {35'b0, e_lir});
        check(po_valid === e_pov, "R8 po_valid", {35'b0, po_valid}, {35'b0, e_pov});
        if (e_pov)
            check(po_data === e_po, "R8 po_data", {4'b0, po_data}, {4'b0, e_po});

        acc_pi = pi_valid && e_pir;
        acc_li = li_push && e_lir;

        if (start) begin
            fq.delete(); bq.delete(); clear_stage();
            m_dir = cfg_dir;
            m_w   = (cfg_width == 2'd0) ? 1 : (cfg_width == 2'd1) ? 2 : 4;
            m_off = int'(cfg_offset);
            m_pos = m_off; m_fpend = 0; m_first = 1;
        end else if (!m_dir) begin
            if (lo_pop && cnt > 0) void'(fq.pop_front());
            if (acc_pi) begin
                for (int i = 0; i < m_w; i++) begin
                    stg[m_pos] = pi_data[i*8 +: 8];
                    sbe[m_pos] = 1;
                    m_pos++;
                    if (m_pos == 4) begin
                        fq.push_back(stage_word());
                        clear_stage();
                        m_pos = 0;
                    end
                end
            end else if (req) begin
                if (stage_any()) begin
                    if (space) begin
                        fq.push_back(stage_word());
                        clear_stage();
                        m_pos = 0; m_fpend = 0;
                    end else m_fpend = 1;
                end else m_fpend = 0;
            end
        end else begin
            if (po_pop && e_pov) for (int i = 0; i < m_w; i++) void'(bq.pop_front());
            if (uload) begin
                w = fq.pop_front();
                k = m_first ? m_off : 0;
                for (int l = k; l < 4; l++) bq.push_back(w[l*8 +: 8]);
                m_first = 0;
            end
            if (acc_li) fq.push_back({4'hF, li_data});
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic begin_xfer(input bit dir, input logic [1:0] wdt, input logic [1:0] off);
        start = 1; cfg_dir = dir; cfg_width = wdt; cfg_offset = off;
        cycle();
        start = 0;
        #1;
        check(level === 4'd0 && empty === 1'b1, "R10 cleared by start", {32'b0, level}, 36'd0);
    endtask

    function automatic logic [31:0] beat_val();
        logic [31:0] r = '0;
        for (int i = 0; i < m_w; i++) r[i*8 +: 8] = 8'(seq + i);
        return r;
    endfunction

    task automatic send_beats(input int n, input int vpct, input int ppct);
        int sent = 0;
        for (int it = 0; it < 400 && sent < n; it++) begin
            pi_valid = ($urandom_range(99, 0) < vpct);
            pi_data  = beat_val();
            lo_pop   = ($urandom_range(99, 0) < ppct);
            cycle();
            if (acc_pi) begin sent++; seq += m_w; end
        end
        pi_valid = 0; lo_pop = 0;
    endtask

    task automatic do_flush(input bit pop_now);
        flush = 1; lo_pop = pop_now;
        cycle();
        flush = 0; lo_pop = 0;
    endtask

    task automatic drain_pack();
        lo_pop = 1;
        for (int it = 0; it < 60 && (fq.size() > 0 || m_fpend); it++) cycle();
        cycle(); cycle();   // R7 pop while empty
        lo_pop = 0;
    endtask

    task automatic unpack_run(input int nwords, input int lpct, input int ppct);
        int sent = 0;
        for (int it = 0; it < 400 && sent < nwords; it++) begin
            li_push = ($urandom_range(99, 0) < lpct);
            li_data = {8'(seq + 3), 8'(seq + 2), 8'(seq + 1), 8'(seq)};
            po_pop  = ($urandom_range(99, 0) < ppct);
            cycle();
            if (acc_li) begin sent++; seq += 4; end
        end
        li_push = 0;
        po_pop  = 1;
        for (int it = 0; it < 60 && (fq.size() > 0 || bq.size() >= m_w); it++) cycle();
        cycle();
        po_pop = 0;
    endtask

    initial begin
        #(150000 * 5);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog R1..all actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(7));
        clear_stage();
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        check(empty === 1'b1 && full === 1'b0 && level === 4'd0, "R1 flags", {32'b0, level}, 36'd0);
        check(lo_valid === 1'b0 && po_valid === 1'b0, "R1 valids", {34'b0, lo_valid, po_valid}, 36'd0);
        @(negedge clk);

        // R2 R3: 8-bit beats, aligned, then flush of a tail (R4)
        begin_xfer(0, 2'd0, 2'd0);
        send_beats(22, 70, 40); do_flush(0); drain_pack();
        // R2: 16-bit beats at odd offset cross words
        begin_xfer(0, 2'd1, 2'd1);
        send_beats(15, 80, 50); do_flush(1); drain_pack();
        // R2 R3: 32-bit beats at offset 3
        begin_xfer(0, 2'd2, 2'd3);
        send_beats(12, 90, 60); do_flush(0); drain_pack();
        // R4: flush with nothing staged
        begin_xfer(0, 2'd1, 2'd0);
        send_beats(4, 100, 0); do_flush(0); do_flush(0); drain_pack();
        // R5 R6 R4: fill to full with a partial staged, pending flush, then push+pop at full
        begin_xfer(0, 2'd2, 2'd1);
        send_beats(10, 100, 0);
        do_flush(0); cycle(); cycle();
        lo_pop = 1; cycle(); lo_pop = 0;
        begin_xfer(0, 2'd2, 2'd1);
        send_beats(8, 100, 0);
        send_beats(6, 100, 100);
        do_flush(0); drain_pack();
        // R10: start while holding data
        begin_xfer(0, 2'd0, 2'd2);
        send_beats(9, 100, 0);
        begin_xfer(1, 2'd0, 2'd2);
        // R8 unpack variants
        unpack_run(6, 70, 60);
        begin_xfer(1, 2'd1, 2'd1);
        unpack_run(7, 80, 50);
        // R9: fill while peripheral idle, then run together
        begin_xfer(1, 2'd2, 2'd3);
        unpack_run(12, 100, 0);
        begin_xfer(1, 2'd2, 2'd0);
        unpack_run(10, 100, 100);
        begin_xfer(0, 2'd0, 2'd0);
        cycle();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule